// File: doc/BRIEF.md
# Processor-to-Peripheral Bus Bridge

This block sits on the data side of a single-master processor. Every processor access comes with an address strobe, a read or write qualifier, a 32-bit byte address, 32-bit write data and four byte enables. The block sorts each access by address into one of three regions. The first is a small window of local 32-bit registers, answered at fixed latencies. The second is an external range, forwarded to a simple peripheral bus that ends each transfer on a ready handshake. Any other address is answered at once with no side effect.

On the peripheral side the block raises a one-cycle address strobe, qualified by a read or a write strobe. It holds the address, write data and byte enables steady until the peripheral reports ready. It then returns a one-cycle ready pulse to the processor, and for reads the data that came with it. The processor-side correctable-error and uncorrectable-error outputs are tied low. The window bases and the number of local registers are parameters.

Top module: `pb_bridge`

## Requirements
- R1: While reset is held and after it is released, `cpu_ready`, `per_as`, `per_rd`, `per_wr` and `cpu_rdata` are 0, and every local register reads as 0.
- R2: The local window covers NUM_REGS*4 bytes from LOCAL_BASE (defaults: 4 registers at 0x0 to 0xF), and `cpu_addr[3:2]` selects the word. For a local write whose strobe is sampled in cycle T, each byte lane with its `cpu_be` bit set is updated at the end of T, lanes with a clear bit keep their value, and `cpu_ready` is 1 in cycle T+1.
- R3: For a local read strobed in cycle T, `cpu_ready` is 0 in T+1 and 1 in T+2, and in T+2 `cpu_rdata` holds the selected register.
- R4: An access to the external range (defaults: address bits [31:30] equal to 2'b10) strobed in cycle T raises `per_as` for cycle T+1 only. In that cycle `per_rd` is 1 for a read, `per_wr` is 1 for a write, and `per_addr`, `per_wdata` and `per_be` equal the processor's address, write data and byte enables.
- R5: `per_addr`, `per_wdata` and `per_be` stay unchanged from the strobe cycle through the cycle in which `per_ready` is first seen high.
- R6: `per_ready` counts only from the cycle after `per_as`, so a high level during the strobe cycle is ignored. If it is first high in cycle T+2+W, `cpu_ready` is 1 in T+3+W and, for a read, `cpu_rdata` equals `per_rdata` from cycle T+2+W. With no wait states an external access takes three cycles.
- R7: `cpu_rdata` is 0 in every cycle where `cpu_ready` is 0, and 0 on the ready cycle of any write.
- R8: Each accepted access produces exactly one `cpu_ready` cycle. A strobe that arrives while an access is still pending is ignored. A strobe in the ready cycle itself is accepted, so back-to-back external accesses complete once every three cycles.
- R9: An access outside both ranges returns `cpu_ready` in T+1 with `cpu_rdata` 0. It raises no peripheral strobe and changes no local register.
- R10: `cpu_ce` and `cpu_ue` are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_as | input | 1 | Processor address strobe |
| cpu_rd | input | 1 | Processor read qualifier |
| cpu_wr | input | 1 | Processor write qualifier |
| cpu_addr | input | 32 | Processor byte address |
| cpu_wdata | input | 32 | Processor write data |
| cpu_be | input | 4 | Processor byte enables |
| cpu_rdata | output | 32 | Read data to the processor, zero outside ready |
| cpu_ready | output | 1 | One-cycle completion pulse per access |
| cpu_ce | output | 1 | Correctable error, tied 0 |
| cpu_ue | output | 1 | Uncorrectable error, tied 0 |
| per_as | output | 1 | Peripheral address strobe, one cycle |
| per_rd | output | 1 | Peripheral read strobe |
| per_wr | output | 1 | Peripheral write strobe |
| per_addr | output | 32 | Peripheral address |
| per_wdata | output | 32 | Peripheral write data |
| per_be | output | 4 | Peripheral byte enables |
| per_rdata | input | 32 | Peripheral read data |
| per_ready | input | 1 | Peripheral completion handshake |

## Verification
The ready cycle that completes one access can coincide with the address strobe of the next. The bench chains accesses so that each new strobe is driven in the same cycle the previous ready appears, mixing local writes, local reads and external transfers. It then checks that the next peripheral strobe or local response lands on the expected cycle. A second overlap is a peripheral ready that arrives during the strobe cycle itself. The bench drives this early ready on every odd wait count and checks that neither the response cycle nor the returned data moves. A processor strobe aimed at a local register while a read is pending is judged by reading that register back later.

// File: rtl/pb_bridge_pkg.sv
package pb_bridge_pkg;

    localparam int unsigned ADDR_W = 32;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned BE_W   = DATA_W / 8;

    typedef enum logic [1:0] {
        CTL_IDLE,
        CTL_LREAD,
        CTL_EXT
    } ctl_state_e;

    typedef enum logic [1:0] {
        XP_IDLE,
        XP_STROBE,
        XP_WAIT
    } xp_state_e;

    typedef enum logic [1:0] {
        RGN_NONE,
        RGN_LOCAL,
        RGN_EXT
    } region_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [BE_W-1:0]   be;
        logic              is_read;
    } bus_req_t;

    function automatic logic in_window(
        input logic [ADDR_W-1:0] a,
        input logic [ADDR_W-1:0] base,
        input logic [ADDR_W-1:0] mask
    );
        return (a & mask) == (base & mask);
    endfunction

    function automatic logic [DATA_W-1:0] merge_bytes(
        input logic [DATA_W-1:0] old_w,
        input logic [DATA_W-1:0] new_w,
        input logic [BE_W-1:0]   lanes
    );
        logic [DATA_W-1:0] res;
        res = old_w;
        for (int i = 0; i < int'(BE_W); i++) begin
            if (lanes[i]) res[i*8 +: 8] = new_w[i*8 +: 8];
        end
        return res;
    endfunction

endpackage

// File: rtl/pb_decode.sv
module pb_decode
    import pb_bridge_pkg::*;
#(
    parameter logic [ADDR_W-1:0] LOCAL_BASE = 32'h0000_0000,
    parameter logic [ADDR_W-1:0] LOCAL_MASK = 32'hFFFF_FFF0,
    parameter logic [ADDR_W-1:0] EXT_BASE   = 32'h8000_0000,
    parameter logic [ADDR_W-1:0] EXT_MASK   = 32'hC000_0000
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region
);
    always_comb begin
        if (in_window(addr, LOCAL_BASE, LOCAL_MASK))
            region = RGN_LOCAL;
        else if (in_window(addr, EXT_BASE, EXT_MASK))
            region = RGN_EXT;
        else
            region = RGN_NONE;
    end
endmodule

// File: rtl/pb_regfile.sv
module pb_regfile
    import pb_bridge_pkg::*;
#(
    parameter int unsigned NUM_REGS = 4,
    parameter int unsigned IDX_W    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [BE_W-1:0]   wr_be,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] words [NUM_REGS];

    for (genvar r = 0; r < int'(NUM_REGS); r++) begin : g_word
        logic [DATA_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst)
                word_q <= '0;
            else if (wr_en && wr_idx == IDX_W'(r))
                word_q <= merge_bytes(word_q, wr_data, wr_be);
        end
        assign words[r] = word_q;
    end

    assign rd_data = words[rd_idx];
endmodule

// File: rtl/pb_ext_port.sv
module pb_ext_port
    import pb_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  bus_req_t          req_in,
    output logic              per_as,
    output logic              per_rd,
    output logic              per_wr,
    output logic [ADDR_W-1:0] per_addr,
    output logic [DATA_W-1:0] per_wdata,
    output logic [BE_W-1:0]   per_be,
    input  logic [DATA_W-1:0] per_rdata,
    input  logic              per_ready,
    output logic              done,
    output logic [DATA_W-1:0] done_rdata,
    output logic              done_is_read
);
    xp_state_e st;
    bus_req_t  hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= XP_IDLE;
            hold <= '0;
        end else begin
            unique case (st)
                XP_IDLE: begin
                    if (start) begin
                        hold <= req_in;
                        st   <= XP_STROBE;
                    end
                end
                XP_STROBE: st <= XP_WAIT;
                XP_WAIT:   if (per_ready) st <= XP_IDLE;
                default:   st <= XP_IDLE;
            endcase
        end
    end

    assign per_as       = (st == XP_STROBE);
    assign per_rd       = per_as & hold.is_read;
    assign per_wr       = per_as & ~hold.is_read;
    assign per_addr     = hold.addr;
    assign per_wdata    = hold.wdata;
    assign per_be       = hold.be;
    assign done         = (st == XP_WAIT) && per_ready;
    assign done_rdata   = per_rdata;
    assign done_is_read = hold.is_read;

    // R4
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        per_as |=> !per_as);

    // R5
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (per_as || (st == XP_WAIT && !per_ready)) |=>
            ($stable(per_addr) && $stable(per_wdata) && $stable(per_be)));

    // R4
    strobe_qual_chk: assert property (@(posedge clk) disable iff (rst)
        (start && st == XP_IDLE) |=> (per_as && (per_rd == $past(req_in.is_read))));
endmodule

// File: rtl/pb_bridge.sv
module pb_bridge
    import pb_bridge_pkg::*;
#(
    parameter int unsigned       NUM_REGS   = 4,
    parameter logic [ADDR_W-1:0] LOCAL_BASE = 32'h0000_0000,
    parameter logic [ADDR_W-1:0] EXT_BASE   = 32'h8000_0000,
    parameter logic [ADDR_W-1:0] EXT_MASK   = 32'hC000_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_as,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic [BE_W-1:0]   cpu_be,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              cpu_ce,
    output logic              cpu_ue,
    output logic              per_as,
    output logic              per_rd,
    output logic              per_wr,
    output logic [ADDR_W-1:0] per_addr,
    output logic [DATA_W-1:0] per_wdata,
    output logic [BE_W-1:0]   per_be,
    input  logic [DATA_W-1:0] per_rdata,
    input  logic              per_ready
);
    localparam int unsigned       IDX_W      = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam logic [ADDR_W-1:0] LOCAL_SPAN = ADDR_W'(NUM_REGS * 4);
    localparam logic [ADDR_W-1:0] LOCAL_MASK = ~(LOCAL_SPAN - 1);

    ctl_state_e        ctl;
    region_e           region;
    logic              accept, lw, lr, xs, nm;
    logic [IDX_W-1:0]  cpu_idx, rd_idx_q;
    logic [DATA_W-1:0] rf_rdata, xp_rdata, rdata_q;
    logic              ready_q, xp_done, xp_is_read;
    bus_req_t          req;

    pb_decode #(
        .LOCAL_BASE(LOCAL_BASE), .LOCAL_MASK(LOCAL_MASK),
        .EXT_BASE(EXT_BASE),     .EXT_MASK(EXT_MASK)
    ) u_decode (
        .addr(cpu_addr), .region(region)
    );

    assign accept  = cpu_as && (cpu_rd || cpu_wr) && (ctl == CTL_IDLE);
    assign lw      = accept && (region == RGN_LOCAL) && !cpu_rd;
    assign lr      = accept && (region == RGN_LOCAL) && cpu_rd;
    assign xs      = accept && (region == RGN_EXT);
    assign nm      = accept && (region == RGN_NONE);
    assign cpu_idx = cpu_addr[IDX_W+1:2];

    assign req = '{addr: cpu_addr, wdata: cpu_wdata, be: cpu_be, is_read: cpu_rd};

    pb_regfile #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst(rst),
        .wr_en(lw), .wr_idx(cpu_idx), .wr_data(cpu_wdata), .wr_be(cpu_be),
        .rd_idx(rd_idx_q), .rd_data(rf_rdata)
    );

    pb_ext_port u_ext (
        .clk(clk), .rst(rst), .start(xs), .req_in(req),
        .per_as(per_as), .per_rd(per_rd), .per_wr(per_wr),
        .per_addr(per_addr), .per_wdata(per_wdata), .per_be(per_be),
        .per_rdata(per_rdata), .per_ready(per_ready),
        .done(xp_done), .done_rdata(xp_rdata), .done_is_read(xp_is_read)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl      <= CTL_IDLE;
            ready_q  <= 1'b0;
            rdata_q  <= '0;
            rd_idx_q <= '0;
        end else begin
            ready_q <= 1'b0;
            rdata_q <= '0;
            unique case (ctl)
                CTL_IDLE: begin
                    if (lw || nm) ready_q <= 1'b1;
                    if (lr) begin
                        ctl      <= CTL_LREAD;
                        rd_idx_q <= cpu_idx;
                    end
                    if (xs) ctl <= CTL_EXT;
                end
                CTL_LREAD: begin
                    ready_q <= 1'b1;
                    rdata_q <= rf_rdata;
                    ctl     <= CTL_IDLE;
                end
                CTL_EXT: begin
                    if (xp_done) begin
                        ready_q <= 1'b1;
                        rdata_q <= xp_is_read ? xp_rdata : '0;
                        ctl     <= CTL_IDLE;
                    end
                end
                default: ctl <= CTL_IDLE;
            endcase
        end
    end

    assign cpu_ready = ready_q;
    assign cpu_rdata = rdata_q;
    assign cpu_ce    = 1'b0;
    assign cpu_ue    = 1'b0;

    // R2
    lwr_latency_chk: assert property (@(posedge clk) disable iff (rst)
        lw |=> cpu_ready);

    // R3
    lrd_latency_chk: assert property (@(posedge clk) disable iff (rst)
        lr |=> (!cpu_ready ##1 cpu_ready));

    // R4
    ext_issue_chk: assert property (@(posedge clk) disable iff (rst)
        xs |=> (per_as && !cpu_ready));

    // R6
    ext_resp_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl == CTL_EXT && xp_done) |=> cpu_ready);

    // R7
    rdata_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !cpu_ready |-> (cpu_rdata == '0));

    // R8
    ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl == CTL_EXT && !xp_done) |=> !cpu_ready);

    // R9
    unmapped_chk: assert property (@(posedge clk) disable iff (rst)
        nm |=> (cpu_ready && cpu_rdata == '0 && !per_as));
endmodule

// File: tb/test_pb_bridge.sv
`timescale 1ns/1ps
module test_pb_bridge;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_as = 1'b0, cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic [3:0]  cpu_be = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_ready, cpu_ce, cpu_ue;
    logic        per_as, per_rd, per_wr;
    logic [31:0] per_addr, per_wdata;
    logic [3:0]  per_be;
    logic [31:0] per_rdata = '0;
    logic        per_ready = 1'b0;

    int checks = 0;
    int failures = 0;
    logic [31:0] mdl [4];

    always #10 clk = ~clk;

    pb_bridge i_pb_bridge (
        .clk(clk), .rst(rst),
        .cpu_as(cpu_as), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
        .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready), .cpu_ce(cpu_ce), .cpu_ue(cpu_ue),
        .per_as(per_as), .per_rd(per_rd), .per_wr(per_wr),
        .per_addr(per_addr), .per_wdata(per_wdata), .per_be(per_be),
        .per_rdata(per_rdata), .per_ready(per_ready)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n, input logic [3:0] be);
        logic [31:0] r;
        r = o;
        for (int i = 0; i < 4; i++) if (be[i]) r[i*8 +: 8] = n[i*8 +: 8];
        return r;
    endfunction

    // One processor access; if b2b, the strobe is driven in the current cycle
    // (the ready cycle of the previous access), otherwise at the next negedge.
    task automatic access(input logic [31:0] a, input logic [31:0] wd, input logic [3:0] be,
                          input bit rd, input int ws, input bit glitch, input bit poke, input bit b2b);
        int rgn;
        logic [31:0] prd;
        rgn = (a < 32'h10) ? 1 : ((a[31:30] == 2'b10) ? 2 : 0);
        prd = {a[15:0], wd[15:0]} ^ 32'h5A5A_3C3C;
        if (!b2b) @(negedge clk);
        cpu_as = 1'b1; cpu_rd = rd; cpu_wr = !rd;
        cpu_addr = a; cpu_wdata = wd; cpu_be = be;
        @(negedge clk);  // cycle T+1
        cpu_as = 1'b0; cpu_rd = 1'b0; cpu_wr = 1'b0;
        cpu_addr = ~a; cpu_wdata = ~wd; cpu_be = ~be;
        if (poke) begin
            cpu_as = 1'b1; cpu_wr = 1'b1; cpu_addr = 32'hC;
            cpu_wdata = 32'hDEAD_BEEF; cpu_be = 4'hF;
        end
        check("R10 ce", 32'(cpu_ce), 32'd0);
        check("R10 ue", 32'(cpu_ue), 32'd0);
        if (rgn == 0 || (rgn == 1 && !rd)) begin
            check(rgn == 0 ? "R9 ready T+1" : "R2 ready T+1", 32'(cpu_ready), 32'd1);
            check("R7 write/unmapped rdata", cpu_rdata, 32'd0);
            check(rgn == 0 ? "R9 no strobe" : "R2 no strobe", 32'(per_as), 32'd0);
            if (rgn == 1) mdl[a[3:2]] = merge(mdl[a[3:2]], wd, be);
        end else if (rgn == 1) begin
            check("R3 no ready T+1", 32'(cpu_ready), 32'd0);
            check("R7 idle rdata", cpu_rdata, 32'd0);
            @(negedge clk);  // T+2
            cpu_as = 1'b0; cpu_wr = 1'b0;
            check("R3 ready T+2", 32'(cpu_ready), 32'd1);
            check("R3 read data", cpu_rdata, mdl[a[3:2]]);
        end else begin
            check("R4 strobe", 32'(per_as), 32'd1);
            check("R4 read qual", 32'(per_rd), 32'(rd));
            check("R4 write qual", 32'(per_wr), 32'(!rd));
            check("R4 addr", per_addr, a);
            check("R4 wdata", per_wdata, wd);
            check("R4 be", 32'(per_be), 32'(be));
            check("R6 no ready at strobe", 32'(cpu_ready), 32'd0);
            if (glitch) begin
                per_ready = 1'b1; per_rdata = 32'hBAD0_BAD0;
            end
            for (int k = 0; k <= ws; k++) begin
                @(negedge clk);
                cpu_as = 1'b0; cpu_wr = 1'b0;
                per_ready = (k == ws);
                per_rdata = (k == ws) ? prd : 32'h0;
                check("R4 strobe single", 32'(per_as), 32'd0);
                check("R5 addr held", per_addr, a);
                check("R5 wdata held", per_wdata, wd);
                check("R5 be held", 32'(per_be), 32'(be));
                check("R6 ready waits", 32'(cpu_ready), 32'd0);
                check("R7 idle rdata", cpu_rdata, 32'd0);
            end
            @(negedge clk);
            per_ready = 1'b0; per_rdata = 32'h0;
            check("R6 ready T+3+W", 32'(cpu_ready), 32'd1);
            check(rd ? "R6 ext read data" : "R7 ext write rdata", cpu_rdata, rd ? prd : 32'd0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) mdl[i] = 32'h0;
        repeat (2) @(negedge clk);
        check("R1 ready in reset", 32'(cpu_ready), 32'd0);
        check("R1 strobe in reset", 32'(per_as), 32'd0);
        check("R1 rdata in reset", cpu_rdata, 32'd0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 ready after reset", 32'(cpu_ready), 32'd0);
        check("R1 strobes after reset", {29'd0, per_as, per_rd, per_wr}, 32'd0);
        // R1: all registers start at zero
        for (int r = 0; r < 4; r++) access(32'(r*4), 32'h0, 4'h0, 1'b1, 0, 1'b0, 1'b0, 1'b0);
        // R2 / R3: every register under every byte-enable pattern
        for (int r = 0; r < 4; r++) begin
            for (int b = 0; b < 16; b++) begin
                access(32'(r*4), 32'(r+1) * 32'h0101_0101 ^ 32'(b) * 32'h1357_9BDF,
                       4'(b), 1'b0, 0, 1'b0, 1'b0, 1'b0);
                access(32'(r*4), 32'h0, 4'h0, 1'b1, 0, 1'b0, 1'b0, 1'b0);
            end
        end
        // R4 / R5 / R6: wait states 0..7, both directions, early ready on odd W
        for (int w = 0; w < 8; w++) begin
            for (int d = 0; d < 2; d++) begin
                access(32'h8000_0000 + 32'(w*256 + d*4), 32'hA5A5_0000 + 32'(w*16 + d),
                       4'(1 << (w % 4)) | 4'(d*8), d[0], w, w[0], 1'b0, 1'b0);
            end
        end
        // R8: strobes driven in the ready cycle of the preceding access
        access(32'h8000_1000, 32'h1111_2222, 4'hF, 1'b0, 0, 1'b0, 1'b0, 1'b0);
        access(32'h9000_0004, 32'h3333_4444, 4'h3, 1'b1, 2, 1'b1, 1'b0, 1'b1);
        access(32'h0000_0004, 32'h5555_6666, 4'hF, 1'b0, 0, 1'b0, 1'b0, 1'b1);
        access(32'hB000_0008, 32'h7777_8888, 4'hC, 1'b1, 0, 1'b0, 1'b0, 1'b1);
        access(32'h0000_0004, 32'h0, 4'h0, 1'b1, 0, 1'b0, 1'b0, 1'b1);
        access(32'h0000_000C, 32'h0, 4'h0, 1'b1, 0, 1'b0, 1'b0, 1'b1);
        // R8: strobes while busy are ignored (target register 3 must not change)
        access(32'h0000_0004, 32'h0, 4'h0, 1'b1, 0, 1'b0, 1'b1, 1'b0);
        access(32'h8000_0010, 32'hCAFE_0001, 4'h5, 1'b1, 3, 1'b0, 1'b1, 1'b0);
        @(negedge clk);
        check("R8 single ready", 32'(cpu_ready), 32'd0);
        access(32'h0000_000C, 32'h0, 4'h0, 1'b1, 0, 1'b0, 1'b0, 1'b1);
        // R9: unmapped accesses
        access(32'h0000_0010, 32'hFFFF_FFFF, 4'hF, 1'b0, 0, 1'b0, 1'b0, 1'b0);
        access(32'h4000_0000, 32'h0, 4'hF, 1'b1, 0, 1'b0, 1'b0, 1'b0);
        access(32'hC000_0020, 32'h1234_5678, 4'hF, 1'b0, 0, 1'b0, 1'b0, 1'b0);
        for (int r = 0; r < 4; r++) access(32'(r*4), 32'h0, 4'h0, 1'b1, 0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        check("R8 quiet after last", 32'(cpu_ready), 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule